// File: doc/BRIEF.md
# Pilot-Driven Common Phase Rotation Corrector

This block sits after equalisation in an OFDM receiver and removes the rotation that is common to every subcarrier of a symbol. Frequency-domain subcarriers arrive one per beat on an AXI-Stream input, in index order, and the last one of each symbol is marked. A per-subcarrier allocation vector classifies each position as null, data or pilot. The pilots of a symbol are summed, and the sums are divided by the configured pilot count to give a cosine and sine estimate. The carriers are QPSK, so no amplitude normalisation is needed.

A whole symbol is held in one of two buffers while its pilot sums build up. Once its last subcarrier has arrived, every data carrier of that symbol is multiplied by the complex conjugate of the estimate and sent out. Pilots and nulls are dropped from the output. While one buffer drains, the other captures the next symbol. The pilot count must be a power of two, so that the division is an arithmetic right shift. Any other count raises an error flag, and symbols captured under that count pass through uncorrected. Any slope across the subcarrier index is left in place: only the common rotation is removed.

Top module: `cpe_tracker`

## Requirements
- R1: Reset is synchronous and active high. While it is held and on the first cycle after it, `m_tvalid` is 0 and `s_tready` is 1.
- R2: Only subcarriers coded 2'b01 (data) reach the output. Codes 2'b00 (null), 2'b10 (pilot) and 2'b11 (reserved) are dropped. Data carriers leave in their input order.
- R3: The estimate pair is the sum of the real parts and the sum of the imaginary parts of the pilot-coded subcarriers of the symbol. Each sum is arithmetically right-shifted by log2(`np_cnt`), which rounds toward minus infinity. `np_cnt` and the allocation vector are sampled while the symbol is captured.
- R4: For an input carrier a+jb and an estimate c+js, the output real part is a*c+b*s and the output imaginary part is b*c-a*s. These are exact signed values, packed as `m_tdata` = {imag, real}, each PW bits wide. Input `s_tdata` is {imag, real}, each DW bits, in two's complement.
- R5: `m_tlast` is 1 on the last data carrier of each symbol and 0 on every other output beat.
- R6: `np_cnt` is supported when it is a power of two from 1 to MAX_NP. `cfg_err` shows, one cycle later, whether the current value is unsupported. A symbol whose last beat is accepted under an unsupported value uses c=1 and s=0, so each of its data carriers leaves unchanged, sign-extended.
- R7: There are two symbol buffers. A symbol can be accepted without stall while the previous symbol waits for output. `s_tready` goes low only when both buffers are occupied. While `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R8: A symbol with no data carriers produces no output beat and still frees its buffer.
- R9: The allocation code of subcarrier k (k counted from 0 at the first beat of the symbol) is `alloc_vec[2k+1:2k]`. Symbols may be shorter than NSC.
- R10: A symbol holds at most NSC subcarriers. The beat at position NSC-1 must carry `s_tlast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 2*DW | Input subcarrier {imag, real} |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Last subcarrier of the symbol |
| s_tready | output | 1 | Block can accept a beat |
| alloc_vec | input | 2*NSC | Two-bit class per subcarrier position |
| np_cnt | input | $clog2(MAX_NP)+1 | Pilot count used as the divisor |
| m_tdata | output | 2*PW | Corrected data carrier {imag, real} |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Last data carrier of the symbol |
| m_tready | input | 1 | Downstream accepts the beat |
| cfg_err | output | 1 | Pilot count unsupported |

## Verification
The checks assume that the source never sends more than NSC beats without `s_tlast`. They also assume that `alloc_vec` and `np_cnt` stay stable from the first beat of a symbol until its last beat is accepted. The stimulus changes both only between symbols and bounds every symbol length at NSC. The output hold property relies on the sink raising `m_tready` in some later cycle. The bench drives `m_tready` from a pseudo-random pattern and holds it low only for a short, bounded time.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
   typedef enum logic [1:0] {
      SC_NULL  = 2'b00,
      SC_DATA  = 2'b01,
      SC_PILOT = 2'b10,
      SC_RSVD  = 2'b11
   } sc_kind_e;
endpackage

// File: rtl/cpe_np_decode.sv
module cpe_np_decode #(
   parameter int MAX_NP = 8,
   parameter int NPW    = $clog2(MAX_NP) + 1,
   parameter int SHW    = $clog2(MAX_NP) + 1
) (
   input  logic [NPW-1:0] np_cnt,
   output logic [SHW-1:0] shift,
   output logic           bad
);
   localparam int LOG2MAX = $clog2(MAX_NP);

   always_comb begin
      bad   = 1'b1;
      shift = '0;
      for (int i = 0; i <= LOG2MAX; i++) begin
         if (np_cnt == NPW'(1 << i)) begin
            bad   = 1'b0;
            shift = SHW'(i);
         end
      end
   end

   // R6
   always_comb begin
      if (!bad) begin
         np_shift_chk: assert ((NPW'(1) << shift) == np_cnt);
      end
   end
endmodule

// File: rtl/cpe_pilot_acc.sv
module cpe_pilot_acc
   import cpe_pkg::*;
#(
   parameter int DW  = 8,
   parameter int SW  = 12,
   parameter int SHW = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 beat,
   input  logic                 last,
   input  sc_kind_e             kind,
   input  logic signed [DW-1:0] re,
   input  logic signed [DW-1:0] im,
   input  logic [SHW-1:0]       shift,
   input  logic                 bypass,
   output logic signed [SW-1:0] est_c,
   output logic signed [SW-1:0] est_s
);
   logic signed [SW-1:0] sum_re, sum_im;
   logic signed [SW-1:0] tot_re, tot_im;
   logic signed [SW-1:0] re_x, im_x;

   assign re_x = {{(SW-DW){re[DW-1]}}, re};
   assign im_x = {{(SW-DW){im[DW-1]}}, im};

   always_comb begin
      tot_re = sum_re;
      tot_im = sum_im;
      if (kind == SC_PILOT) begin
         tot_re = sum_re + re_x;
         tot_im = sum_im + im_x;
      end
      if (bypass) begin
         est_c = SW'(1);
         est_s = '0;
      end else begin
         est_c = tot_re >>> shift;
         est_s = tot_im >>> shift;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_re <= '0;
         sum_im <= '0;
      end else if (beat) begin
         if (last) begin
            sum_re <= '0;
            sum_im <= '0;
         end else begin
            sum_re <= tot_re;
            sum_im <= tot_im;
         end
      end
   end
endmodule

// File: rtl/cpe_conj_mult.sv
module cpe_conj_mult #(
   parameter int DW = 8,
   parameter int SW = 12,
   parameter int PW = 21
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic signed [SW-1:0] c,
   input  logic signed [SW-1:0] s,
   output logic signed [PW-1:0] pr,
   output logic signed [PW-1:0] pi
);
   logic signed [PW-1:0] ax, bx, cx, sx;

   assign ax = {{(PW-DW){a[DW-1]}}, a};
   assign bx = {{(PW-DW){b[DW-1]}}, b};
   assign cx = {{(PW-SW){c[SW-1]}}, c};
   assign sx = {{(PW-SW){s[SW-1]}}, s};

   assign pr = ax * cx + bx * sx;
   assign pi = bx * cx - ax * sx;

   // R6
   always_comb begin
      if (c == SW'(1) && s == '0) begin
         pass_chk: assert (pr == ax && pi == bx);
      end
   end
endmodule

// File: rtl/cpe_tracker.sv
module cpe_tracker
   import cpe_pkg::*;
#(
   parameter int NSC    = 16,
   parameter int DW     = 8,
   parameter int MAX_NP = 8
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [2*DW-1:0]                      s_tdata,
   input  logic                                 s_tvalid,
   input  logic                                 s_tlast,
   output logic                                 s_tready,
   input  logic [2*NSC-1:0]                     alloc_vec,
   input  logic [$clog2(MAX_NP):0]              np_cnt,
   output logic [2*(2*DW+$clog2(NSC)+1)-1:0]    m_tdata,
   output logic                                 m_tvalid,
   output logic                                 m_tlast,
   input  logic                                 m_tready,
   output logic                                 cfg_err
);
   localparam int IW  = $clog2(NSC);
   localparam int SW  = DW + IW;
   localparam int PW  = DW + SW + 1;
   localparam int NPW = $clog2(MAX_NP) + 1;
   localparam int SHW = $clog2(MAX_NP) + 1;

   generate
      if ((MAX_NP & (MAX_NP - 1)) != 0) begin : g_np_pow2
         $error("MAX_NP must be a power of two");
      end
      if (NSC < 2) begin : g_nsc_min
         $error("NSC must be at least 2");
      end
      if (MAX_NP > NSC) begin : g_np_fit
         $error("MAX_NP cannot exceed NSC");
      end
   endgenerate

   logic signed [DW-1:0] re_mem [2][NSC];
   logic signed [DW-1:0] im_mem [2][NSC];
   sc_kind_e             kind_mem [2][NSC];
   logic [IW-1:0]        len_m1 [2];
   logic [IW-1:0]        lastd [2];
   logic signed [SW-1:0] est_c_b [2];
   logic signed [SW-1:0] est_s_b [2];
   logic [1:0]           full;

   logic          wsel, rsel;
   logic [IW-1:0] widx, rptr;
   logic [IW-1:0] lastd_run;

   logic                 beat;
   sc_kind_e             kind_in;
   logic signed [DW-1:0] in_re, in_im;
   logic [SHW-1:0]       np_shift;
   logic                 np_bad;
   logic signed [SW-1:0] est_c_n, est_s_n;

   assign in_re    = s_tdata[DW-1:0];
   assign in_im    = s_tdata[2*DW-1:DW];
   assign kind_in  = sc_kind_e'(alloc_vec[{widx, 1'b0} +: 2]);
   assign s_tready = !full[wsel];
   assign beat     = s_tvalid && s_tready;

   cpe_np_decode #(.MAX_NP(MAX_NP), .NPW(NPW), .SHW(SHW)) np_dec_i (
      .np_cnt (np_cnt),
      .shift  (np_shift),
      .bad    (np_bad)
   );

   cpe_pilot_acc #(.DW(DW), .SW(SW), .SHW(SHW)) acc_i (
      .clk    (clk),
      .rst    (rst),
      .beat   (beat),
      .last   (s_tlast),
      .kind   (kind_in),
      .re     (in_re),
      .im     (in_im),
      .shift  (np_shift),
      .bypass (np_bad),
      .est_c  (est_c_n),
      .est_s  (est_s_n)
   );

   always_ff @(posedge clk) begin
      if (rst) cfg_err <= 1'b0;
      else     cfg_err <= np_bad;
   end

   // capture side
   always_ff @(posedge clk) begin
      if (rst) begin
         wsel      <= 1'b0;
         widx      <= '0;
         lastd_run <= '0;
      end else if (beat) begin
         if (s_tlast) begin
            wsel      <= !wsel;
            widx      <= '0;
            lastd_run <= '0;
         end else begin
            widx <= widx + 1'b1;
            if (kind_in == SC_DATA) lastd_run <= widx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (beat) begin
         re_mem[wsel][widx]   <= in_re;
         im_mem[wsel][widx]   <= in_im;
         kind_mem[wsel][widx] <= kind_in;
         if (s_tlast) begin
            len_m1[wsel]  <= widx;
            lastd[wsel]   <= (kind_in == SC_DATA) ? widx : lastd_run;
            est_c_b[wsel] <= est_c_n;
            est_s_b[wsel] <= est_s_n;
         end
      end
   end

   // read side
   sc_kind_e cur_kind;
   logic     adv, done;

   assign cur_kind = kind_mem[rsel][rptr];
   assign m_tvalid = full[rsel] && (cur_kind == SC_DATA);
   assign adv      = full[rsel] && (!m_tvalid || m_tready);
   assign done     = adv && (rptr == len_m1[rsel]);
   assign m_tlast  = m_tvalid && (rptr == lastd[rsel]);

   always_ff @(posedge clk) begin
      if (rst) begin
         rsel <= 1'b0;
         rptr <= '0;
      end else if (adv) begin
         if (done) begin
            rsel <= !rsel;
            rptr <= '0;
         end else begin
            rptr <= rptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         full <= '0;
      end else begin
         for (int b = 0; b < 2; b++) begin
            if (beat && s_tlast && wsel == b[0]) full[b] <= 1'b1;
            else if (done && rsel == b[0])       full[b] <= 1'b0;
         end
      end
   end

   logic signed [PW-1:0] out_re, out_im;

   cpe_conj_mult #(.DW(DW), .SW(SW), .PW(PW)) mult_i (
      .a  (re_mem[rsel][rptr]),
      .b  (im_mem[rsel][rptr]),
      .c  (est_c_b[rsel]),
      .s  (est_s_b[rsel]),
      .pr (out_re),
      .pi (out_im)
   );

   assign m_tdata = {out_im, out_re};

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

   // R7
   busy_pair_chk: assert property (@(posedge clk) disable iff (rst)
      !s_tready |-> full[rsel] && full[!rsel]);

   // R10
   len_bound_chk: assert property (@(posedge clk) disable iff (rst)
      s_tvalid && widx == IW'(NSC - 1) |-> s_tlast);

   // R5
   last_tail_chk: assert property (@(posedge clk) disable iff (rst)
      m_tvalid && m_tready && m_tlast |=> !(m_tvalid && rsel == $past(rsel)));
endmodule

// File: tb/cpe_tracker_tb.sv
module cpe_tracker_tb_top;
   localparam int NSC    = 16;
   localparam int DW     = 8;
   localparam int MAX_NP = 8;
   localparam int IW     = $clog2(NSC);
   localparam int SW     = DW + IW;
   localparam int PW     = DW + SW + 1;
   localparam int NPW    = $clog2(MAX_NP) + 1;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [2*DW-1:0]     s_tdata = '0;
   logic                s_tvalid = 1'b0;
   logic                s_tlast = 1'b0;
   logic                s_tready;
   logic [2*NSC-1:0]    alloc_vec = '0;
   logic [NPW-1:0]      np_cnt = NPW'(4);
   logic [2*PW-1:0]     m_tdata;
   logic                m_tvalid;
   logic                m_tlast;
   logic                m_tready = 1'b0;
   logic                cfg_err;

   always #4 clk = !clk;

   cpe_tracker #(.NSC(NSC), .DW(DW), .MAX_NP(MAX_NP)) dut_i (
      .clk(clk), .rst(rst),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
      .alloc_vec(alloc_vec), .np_cnt(np_cnt),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
      .cfg_err(cfg_err)
   );

   int total = 0;
   int bad = 0;
   int rdy_mode = 0;
   int stall_cnt = 0;
   int eq_re[$];
   int eq_im[$];
   bit eq_last[$];
   int kinds[NSC];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int samp_re(input int sym, input int k);
      return ((k * 29 + sym * 53 + 7) % 256) - 128;
   endfunction
   function automatic int samp_im(input int sym, input int k);
      return ((k * 71 + sym * 17 + 101) % 256) - 128;
   endfunction

   // pilots spread evenly, one null and one reserved slot, data elsewhere
   task automatic set_pattern(input int npat);
      for (int k = 0; k < NSC; k++) begin
         if (npat > 0 && (k % (NSC / npat)) == 0) kinds[k] = 2;
         else if (k == 5)                         kinds[k] = 0;
         else if (k == NSC - 1)                   kinds[k] = 3;
         else                                     kinds[k] = 1;
      end
   endtask

   // R3 R4 R6 expected model, then drive the symbol
   task automatic send_sym(input int sym, input int len, input int np);
      int sre, sim, c, s, sh, lastk;
      bit okc;
      sre = 0; sim = 0; lastk = -1; okc = 0; sh = 0;
      for (int i = 0; i <= 3; i++) if (np == (1 << i)) begin okc = 1; sh = i; end
      for (int k = 0; k < len; k++) begin
         if (kinds[k] == 2) begin
            sre += samp_re(sym, k);
            sim += samp_im(sym, k);
         end
         if (kinds[k] == 1) lastk = k;
      end
      if (okc) begin c = sre >>> sh; s = sim >>> sh; end
      else     begin c = 1; s = 0; end
      for (int k = 0; k < len; k++) begin
         if (kinds[k] == 1) begin
            eq_re.push_back(samp_re(sym, k) * c + samp_im(sym, k) * s);
            eq_im.push_back(samp_im(sym, k) * c - samp_re(sym, k) * s);
            eq_last.push_back(k == lastk);
         end
      end
      np_cnt = NPW'(np);
      for (int k = 0; k < NSC; k++) alloc_vec[2*k +: 2] = 2'(kinds[k]);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         s_tvalid = 1'b1;
         s_tdata  = {8'(samp_im(sym, k)), 8'(samp_re(sym, k))};
         s_tlast  = (k == len - 1);
         #1;
         while (!s_tready) begin
            stall_cnt++;
            @(negedge clk);
            #1;
         end
      end
      @(negedge clk);
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
   endtask

   task automatic drain();
      int n;
      n = 0;
      while ((eq_re.size() != 0 || m_tvalid) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(eq_re.size() == 0, "R2", "expected beats left over", eq_re.size(), 0);
   endtask

   // sink: drives m_tready and compares every accepted beat (R2 R4 R5)
   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (rdy_mode == 0)      m_tready = 1'b1;
         else if (rdy_mode == 1) m_tready = lfsr[0] | lfsr[3];
         else                    m_tready = 1'b0;
         #1;
         if (m_tvalid && m_tready && !rst) begin
            if (eq_re.size() == 0) begin
               chk(1'b0, "R2", "unexpected output beat", 1, 0);
            end else begin
               int er, ei;
               bit el;
               er = eq_re.pop_front();
               ei = eq_im.pop_front();
               el = eq_last.pop_front();
               chk(int'($signed(m_tdata[PW-1:0])) == er, "R4", "real part",
                   int'($signed(m_tdata[PW-1:0])), er);
               chk(int'($signed(m_tdata[2*PW-1:PW])) == ei, "R4", "imag part",
                   int'($signed(m_tdata[2*PW-1:PW])), ei);
               chk(m_tlast == el, "R5", "last marker", m_tlast, el);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int sym;
      logic [2*PW-1:0] held;
      sym = 0;
      repeat (3) @(negedge clk);
      #1;
      // R1
      chk(m_tvalid == 1'b0, "R1", "m_tvalid in reset", m_tvalid, 0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", m_tvalid, 0);
      chk(s_tready == 1'b1, "R1", "s_tready after reset", s_tready, 1);
      chk(cfg_err == 1'b0, "R6", "cfg_err after reset", cfg_err, 0);

      // R2 R3 R4 R9: sweep every supported pilot count under two sink patterns
      for (int mode = 0; mode < 2; mode++) begin
         rdy_mode = mode;
         for (int e = 0; e <= 3; e++) begin
            set_pattern(1 << e);
            for (int r = 0; r < 3; r++) begin
               send_sym(sym, NSC, 1 << e);
               sym++;
            end
         end
      end
      drain();

      // R6: every encodable pilot count
      for (int v = 0; v < (1 << NPW); v++) begin
         bit exp_bad;
         exp_bad = !(v == 1 || v == 2 || v == 4 || v == 8);
         @(negedge clk);
         np_cnt = NPW'(v);
         repeat (2) @(negedge clk);
         #1;
         chk(cfg_err == exp_bad, "R6", "cfg_err for count", cfg_err, exp_bad);
      end

      // R6: unsupported count passes data unchanged
      rdy_mode = 1;
      set_pattern(4);
      send_sym(sym, NSC, 3);
      sym++;
      send_sym(sym, NSC, 6);
      sym++;

      // R9: short symbols end early, codes taken from low positions
      set_pattern(2);
      send_sym(sym, 7, 2);
      sym++;
      set_pattern(8);
      send_sym(sym, 3, 8);
      sym++;

      // R8: symbol without data, then a normal one
      for (int k = 0; k < NSC; k++) kinds[k] = (k % 2 == 0) ? 2 : 0;
      send_sym(sym, NSC, 8);
      sym++;
      set_pattern(4);
      send_sym(sym, NSC, 4);
      sym++;
      drain();

      // R7: second symbol accepted while first waits, then both buffers busy
      rdy_mode = 2;
      @(negedge clk);
      stall_cnt = 0;
      set_pattern(2);
      send_sym(sym, NSC, 2);
      sym++;
      send_sym(sym, NSC, 2);
      sym++;
      chk(stall_cnt == 0, "R7", "stalls while one buffer free", stall_cnt, 0);
      #1;
      chk(s_tready == 1'b0, "R7", "s_tready with both buffers busy", s_tready, 0);
      repeat (4) @(negedge clk);
      #2;
      held = m_tdata;
      chk(m_tvalid == 1'b1, "R7", "m_tvalid under stall", m_tvalid, 1);
      repeat (3) @(negedge clk);
      #2;
      chk(m_tdata == held, "R7", "m_tdata held under stall", 0, 0);
      chk(m_tvalid == 1'b1, "R7", "m_tvalid held under stall", m_tvalid, 1);
      rdy_mode = 1;
      drain();
      #1;
      chk(s_tready == 1'b1, "R7", "s_tready after drain", s_tready, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule